// File: doc/BRIEF.md
# Power-Up Command Gating Controller

This block stands between a serial flash model's instruction decoder and its core logic. It uses two supply-monitor flags to decide which instructions may run. Both flags are already synchronous to the free-running clock. The first flag reports that the supply is above the write-inhibit threshold. The second reports that the supply is above the minimum operating level.

The block runs two separate power-up timers. The write timer starts when the write-inhibit flag rises. The select timer starts when the minimum-level flag rises. Read access is therefore granted earlier than write-type access.

The permission decision is taken once, when chip select goes active. It is then held for the rest of that transaction. If the supply drops below the write-inhibit threshold, everything shuts down at once and both timers restart. While the block is held in reset it reports an off mode. While the timers run it reports a warm-up mode. Once both timers have expired it reports standby. It never reports the deep-sleep code.

Top module: `pwr_cmd_gate`

## Requirements
- R1: While `aboveInhibit` is 0, `coreRst` is 1, `readOk` and `writeOk` are 0, and `pwrMode` is 2'b00 (off). This holds whatever the chip select and opcode class are.
- R2: `welClr` is 1 for exactly the one cycle after the first clock edge at which `aboveInhibit` is sampled 1 following reset. At all other times it is 0.
- R3: A transaction whose select edge comes before `WR_DELAY` consecutive clock edges with `aboveInhibit` high never gets `writeOk`.
- R4: A transaction whose select edge comes after at least `SEL_DELAY` consecutive edges with `aboveMin` high gets `readOk`, provided the opcode class is read. This holds even if the write timer has not yet expired.
- R5: A transaction whose select edge comes before the select delay has elapsed is ignored for its whole duration. `readOk` and `writeOk` stay 0 in that transaction, even if the delay expires while it is still running.
- R6: `writeOk` needs two things at the select edge: the write timer has expired, and `aboveMin` is 1.
- R7: Once a transaction has been granted, changes of `aboveMin` do not change `readOk` or `writeOk` until chip select is released.
- R8: When `aboveInhibit` falls during a transaction, `readOk` and `writeOk` go to 0 in the same cycle and `coreRst` goes to 1. Both timers also restart.
- R9: A one-cycle drop of `aboveMin` restarts only the select timer. The write timer keeps its progress.
- R10: `pwrMode` is 2'b01 (warm-up) while the supply is above the inhibit threshold but either timer is still running. It is 2'b10 (standby) once both timers have expired. It is never 2'b11.
- R11: The opcode class encoding is 2'b01 for read and 2'b10 for write-type. Codes 2'b00 and 2'b11 grant neither permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| aboveInhibit | input | 1 | Supply is above the write-inhibit threshold |
| aboveMin | input | 1 | Supply is above the minimum operating level |
| csN | input | 1 | Chip select, active low |
| opClass | input | 2 | Decoded opcode class (01 read, 10 write-type, others neither) |
| coreRst | output | 1 | Reset to the core logic |
| readOk | output | 1 | Current read instruction may execute |
| writeOk | output | 1 | Current write-type instruction may execute |
| welClr | output | 1 | One-cycle clear of the write enable latch |
| pwrMode | output | 2 | 00 off, 01 warm-up, 10 standby |

## Verification
The select edge is placed exactly one cycle before and exactly on each timer's expiry. This separates an off-by-one fault in either counter from correct timing.

Several supply patterns are applied:
- the minimum-level flag held low while the write timer runs out;
- a minimum-level glitch;
- an inhibit drop in the middle of a granted transaction.

These patterns show which timer each flag clears, and whether the decision is latched or re-evaluated cycle by cycle. Transactions are also run with each opcode class, and with chip select held across power-up, to confirm that permission follows the class encoding and the select edge only.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_OTHER = 2'b11
  } opClass_e;

  typedef enum logic [1:0] {
    MODE_OFF       = 2'b00,
    MODE_WARMUP    = 2'b01,
    MODE_STANDBY   = 2'b10,
    MODE_DEEPSLEEP = 2'b11
  } pwrMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clrWr;     // restart write timer
    logic clrSel;    // restart select timer
    logic sessLoad;  // latch a decision at the select edge
    logic sessDrop;  // release the session
    logic minOk;     // minimum level present right now
  } gateStb_t;
endpackage

// File: rtl/pcg_timer.sv
module pcg_timer #(
  parameter int DELAY = 16
) (
  input  logic clk,
  input  logic clr,
  output logic done
);
  localparam int W = $clog2(DELAY + 1);
  localparam logic [W-1:0] LIMIT = W'(DELAY);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)
      cnt <= '0;
    else if (cnt != LIMIT)
      cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);
endmodule

// File: rtl/pcg_datapath.sv
module pcg_datapath
  import pcg_pkg::*;
#(
  parameter int WR_DELAY  = 40,
  parameter int SEL_DELAY = 12
) (
  input  logic     clk,
  input  gateStb_t stb,
  output logic     wrDone,
  output logic     selDone,
  output logic     sessRead,
  output logic     sessWrite
);
  localparam int NTIMERS = 2;
  logic [NTIMERS-1:0] timerClr;
  logic [NTIMERS-1:0] timerDone;

  assign timerClr = {stb.clrSel, stb.clrWr};

  for (genvar i = 0; i < NTIMERS; i++) begin : g_timer
    localparam int D = (i == 0) ? WR_DELAY : SEL_DELAY;
    pcg_timer #(.DELAY(D)) u_timer (
      .clk (clk),
      .clr (timerClr[i]),
      .done(timerDone[i])
    );
  end

  assign wrDone  = timerDone[0];
  assign selDone = timerDone[1];

  always_ff @(posedge clk) begin
    if (stb.sessDrop) begin
      sessRead  <= 1'b0;
      sessWrite <= 1'b0;
    end else if (stb.sessLoad) begin
      sessRead  <= selDone & stb.minOk;
      sessWrite <= selDone & wrDone & stb.minOk;
    end
  end
endmodule

// File: rtl/pcg_control.sv
module pcg_control
  import pcg_pkg::*;
(
  input  logic       clk,
  input  logic       aboveInhibit,
  input  logic       aboveMin,
  input  logic       csN,
  input  logic [1:0] opClass,
  input  logic       wrDone,
  input  logic       selDone,
  input  logic       sessRead,
  input  logic       sessWrite,
  output gateStb_t   stb,
  output logic       coreRst,
  output logic       readOk,
  output logic       writeOk,
  output logic       welClr,
  output logic [1:0] pwrMode
);
  logic csPrev;
  logic inhPrev;
  pwrMode_e modeNow;

  always_ff @(posedge clk) begin
    csPrev  <= aboveInhibit ? csN : 1'b1;
    inhPrev <= aboveInhibit;
    welClr  <= aboveInhibit & ~inhPrev;
  end

  always_comb begin
    stb.clrWr    = ~aboveInhibit;
    stb.clrSel   = ~aboveInhibit | ~aboveMin;
    stb.sessLoad = aboveInhibit & ~csN & csPrev;
    stb.sessDrop = ~aboveInhibit | csN;
    stb.minOk    = aboveMin;
  end

  always_comb begin
    if (!aboveInhibit)
      modeNow = MODE_OFF;
    else if (wrDone && selDone)
      modeNow = MODE_STANDBY;
    else
      modeNow = MODE_WARMUP;
  end

  assign pwrMode = modeNow;
  assign coreRst = ~aboveInhibit;
  assign readOk  = aboveInhibit & ~csN & sessRead  & (opClass == OP_READ);
  assign writeOk = aboveInhibit & ~csN & sessWrite & (opClass == OP_WRITE);
endmodule

// File: rtl/pwr_cmd_gate.sv
module pwr_cmd_gate
  import pcg_pkg::*;
#(
  parameter int WR_DELAY  = 40,
  parameter int SEL_DELAY = 12
) (
  input  logic       clk,
  input  logic       aboveInhibit,
  input  logic       aboveMin,
  input  logic       csN,
  input  logic [1:0] opClass,
  output logic       coreRst,
  output logic       readOk,
  output logic       writeOk,
  output logic       welClr,
  output logic [1:0] pwrMode
);
  gateStb_t stb;
  logic wrDone, selDone, sessRead, sessWrite;

  pcg_control u_ctrl (
    .clk         (clk),
    .aboveInhibit(aboveInhibit),
    .aboveMin    (aboveMin),
    .csN         (csN),
    .opClass     (opClass),
    .wrDone      (wrDone),
    .selDone     (selDone),
    .sessRead    (sessRead),
    .sessWrite   (sessWrite),
    .stb         (stb),
    .coreRst     (coreRst),
    .readOk      (readOk),
    .writeOk     (writeOk),
    .welClr      (welClr),
    .pwrMode     (pwrMode)
  );

  pcg_datapath #(.WR_DELAY(WR_DELAY), .SEL_DELAY(SEL_DELAY)) u_dp (
    .clk      (clk),
    .stb      (stb),
    .wrDone   (wrDone),
    .selDone  (selDone),
    .sessRead (sessRead),
    .sessWrite(sessWrite)
  );
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker #(
  parameter int WR_DELAY = 40
) (
  input logic       clk,
  input logic       aboveInhibit,
  input logic       csN,
  input logic [1:0] opClass,
  input logic       coreRst,
  input logic       readOk,
  input logic       writeOk,
  input logic       welClr,
  input logic [1:0] pwrMode
);
  logic [31:0] upCnt;

  always_ff @(posedge clk) begin
    if (!aboveInhibit)
      upCnt <= '0;
    else if (upCnt != 32'hFFFF_FFFF)
      upCnt <= upCnt + 1'b1;
  end

  assert_off_state_R1: assert property (@(posedge clk)
    !aboveInhibit |-> (coreRst && !readOk && !writeOk && pwrMode == 2'b00));

  assert_wel_single_R2: assert property (@(posedge clk) disable iff (!aboveInhibit)
    welClr |=> !welClr);

  assert_write_wait_R3: assert property (@(posedge clk) disable iff (!aboveInhibit)
    writeOk |-> (upCnt >= WR_DELAY));

  assert_decision_held_R7: assert property (@(posedge clk) disable iff (!aboveInhibit)
    (!csN && $past(!csN) && $past(!csN, 2) && $past(aboveInhibit) &&
     $past(aboveInhibit, 2) && opClass == $past(opClass))
    |-> (readOk == $past(readOk) && writeOk == $past(writeOk)));

  assert_no_deepsleep_R10: assert property (@(posedge clk)
    pwrMode != 2'b11);

  assert_one_permit_R11: assert property (@(posedge clk)
    !(readOk && writeOk));
endmodule

bind pwr_cmd_gate pcg_checker #(.WR_DELAY(WR_DELAY)) u_chk (
  .clk         (clk),
  .aboveInhibit(aboveInhibit),
  .csN         (csN),
  .opClass     (opClass),
  .coreRst     (coreRst),
  .readOk      (readOk),
  .writeOk     (writeOk),
  .welClr      (welClr),
  .pwrMode     (pwrMode)
);

// File: tb/pwr_cmd_gate_test.sv
module pwr_cmd_gate_test;
  localparam int WR_DELAY  = 40;
  localparam int SEL_DELAY = 12;

  logic clk = 1'b0;
  logic aboveInhibit = 1'b0;
  logic aboveMin = 1'b0;
  logic csN = 1'b1;
  logic [1:0] opClass = 2'b00;
  logic coreRst, readOk, writeOk, welClr;
  logic [1:0] pwrMode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_cmd_gate #(.WR_DELAY(WR_DELAY), .SEL_DELAY(SEL_DELAY)) uut (
    .clk(clk), .aboveInhibit(aboveInhibit), .aboveMin(aboveMin), .csN(csN),
    .opClass(opClass), .coreRst(coreRst), .readOk(readOk), .writeOk(writeOk),
    .welClr(welClr), .pwrMode(pwrMode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic powerCycle();
    aboveInhibit = 1'b0; aboveMin = 1'b0; csN = 1'b1; opClass = 2'b00;
    repeat (3) @(negedge clk);
  endtask

  task automatic raiseBoth(input int k);
    aboveInhibit = 1'b1; aboveMin = 1'b1;
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic beginTxn(input logic [1:0] op);
    csN = 1'b0; opClass = op;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic endTxn();
    csN = 1'b1; opClass = 2'b00;
    @(negedge clk);
  endtask

  task automatic testReset();
    powerCycle();
    csN = 1'b0; opClass = 2'b01;
    @(negedge clk);
    chk("R1 coreRst", coreRst, 1);
    chk("R1 readOk", readOk, 0);
    chk("R1 pwrMode", pwrMode, 0);
    opClass = 2'b10; #1;
    chk("R1 writeOk", writeOk, 0);
    csN = 1'b1; opClass = 2'b00;
    @(negedge clk);
  endtask

  task automatic testWelPulse();
    powerCycle();
    aboveInhibit = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 welClr pulse", welClr, 1);
    chk("R1 coreRst released", coreRst, 0);
    @(negedge clk);
    chk("R2 welClr single", welClr, 0);
    chk("R10 warm-up", pwrMode, 1);
    repeat (SEL_DELAY + 2) @(negedge clk);
    beginTxn(2'b01);
    chk("R5 min low read", readOk, 0);
    endTxn();
  endtask

  task automatic testReadEarly();
    powerCycle();
    raiseBoth(SEL_DELAY - 1);
    beginTxn(2'b01);
    chk("R5 early read", readOk, 0);
    repeat (SEL_DELAY + 2) @(negedge clk);
    chk("R5 early read held", readOk, 0);
    endTxn();
  endtask

  task automatic testReadOnTime();
    powerCycle();
    raiseBoth(SEL_DELAY);
    beginTxn(2'b01);
    chk("R4 read on time", readOk, 1);
    chk("R10 warm-up", pwrMode, 1);
    opClass = 2'b10; #1;
    chk("R3 write before delay", writeOk, 0);
    endTxn();
  endtask

  task automatic testWriteEdge();
    powerCycle();
    raiseBoth(WR_DELAY - 1);
    beginTxn(2'b10);
    chk("R3 write one early", writeOk, 0);
    endTxn();
    powerCycle();
    raiseBoth(WR_DELAY);
    beginTxn(2'b10);
    chk("R6 write on time", writeOk, 1);
    chk("R10 standby", pwrMode, 2);
    opClass = 2'b00; #1;
    chk("R11 class 00 read", readOk, 0);
    chk("R11 class 00 write", writeOk, 0);
    opClass = 2'b11; #1;
    chk("R11 class 11 read", readOk, 0);
    chk("R11 class 11 write", writeOk, 0);
    endTxn();
  endtask

  task automatic testMinLow();
    powerCycle();
    aboveInhibit = 1'b1;
    repeat (WR_DELAY + 4) @(negedge clk);
    beginTxn(2'b10);
    chk("R6 min low write", writeOk, 0);
    opClass = 2'b01; #1;
    chk("R6 min low read", readOk, 0);
    endTxn();
  endtask

  task automatic testHold();
    powerCycle();
    raiseBoth(WR_DELAY + 1);
    beginTxn(2'b01);
    chk("R7 granted read", readOk, 1);
    aboveMin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 read held", readOk, 1);
    opClass = 2'b10; #1;
    chk("R7 write held", writeOk, 1);
    chk("R10 back to warm-up", pwrMode, 1);
    endTxn();
    beginTxn(2'b01);
    chk("R5 new select min low", readOk, 0);
    endTxn();
  endtask

  task automatic testDrop();
    powerCycle();
    raiseBoth(WR_DELAY + 1);
    beginTxn(2'b10);
    chk("R8 granted write", writeOk, 1);
    aboveInhibit = 1'b0; #1;
    chk("R8 write cut", writeOk, 0);
    chk("R8 coreRst", coreRst, 1);
    @(negedge clk);
    csN = 1'b1; opClass = 2'b00;
    raiseBoth(SEL_DELAY);
    beginTxn(2'b10);
    chk("R8 write timer restarted", writeOk, 0);
    opClass = 2'b01; #1;
    chk("R8 read after restart", readOk, 1);
    endTxn();
  endtask

  task automatic testGlitch();
    powerCycle();
    raiseBoth(WR_DELAY + 1);
    aboveMin = 1'b0;
    @(negedge clk);
    aboveMin = 1'b1;
    beginTxn(2'b01);
    chk("R9 select timer restarted", readOk, 0);
    endTxn();
    aboveMin = 1'b0;
    @(negedge clk);
    aboveMin = 1'b1;
    repeat (SEL_DELAY) @(posedge clk);
    @(negedge clk);
    beginTxn(2'b10);
    chk("R9 write timer kept", writeOk, 1);
    opClass = 2'b01; #1;
    chk("R9 read regained", readOk, 1);
    endTxn();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testWelPulse();
    testReadEarly();
    testReadOnTime();
    testWriteEdge();
    testMinLow();
    testHold();
    testDrop();
    testGlitch();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule